// File: doc/BRIEF.md
# DRAM Rank/Bank/Row Address Mapper

This block sits at the front of a DRAM memory controller. It turns a physical byte address into the rank, bank and row a request should use. First it drops the byte offset inside a cache line. The remaining line index is then split into fields by one of two interleaving schemes, chosen per request by a one-bit mode input.

- **Open-page scheme.** The column field is the least significant field, so a run of sequential cache lines stays inside one open row.
- **Closed-page scheme.** The bank and rank fields are the least significant, so sequential lines land on different banks and can proceed in parallel.

The column field is consumed to reach the fields above it, but it is never output. Address bits above the row field are ignored.

Requests enter through a valid/ready handshake. The decoded coordinates are registered and presented one cycle after acceptance, behind a second valid/ready pair. The geometry is fixed by parameters: line size, lines per row buffer, banks per rank, ranks per channel and rows per bank. Every one of them must be a power of two, so each division is a fixed shift and each modulo is a mask. An elaboration-time check flags any other value.

Top module: `dram_coord_mapper`

## Requirements
- R1: While `rst` is high at a rising edge, the next cycle shows `outValid` = 0 and `outRank`, `outBank` and `outRow` all zero. `inReady` is 1 whenever no result is held.
- R2: Byte addresses that differ only in the low log2(LINE_BYTES) bits decode to identical rank, bank and row in either mode.
- R3: With `inMode` = 0 (open-page), the line index (address divided by LINE_BYTES) holds, from least significant upward: column (log2 LINES_PER_ROW bits), bank, rank, row. Each output is zero-extended to its port width (rank 8 bits, bank 16, row 16).
- R4: With `inMode` = 1 (closed-page), the line index holds, from least significant upward: bank, rank, column, row. The outputs are zero-extended as in R3.
- R5: In open-page mode, LINES_PER_ROW consecutive lines starting at a line index that is a multiple of LINES_PER_ROW all decode to the same rank, bank and row.
- R6: In closed-page mode, BANKS consecutive lines starting at a line index that is a multiple of BANKS decode to banks 0, 1, ..., BANKS-1 in order.
- R7: Address bits above the row field have no effect on any output.
- R8: A request accepted at a rising edge (`inValid` and `inReady` both high) gives `outValid` = 1 with its coordinates after that edge. If `outReady` is high and no new request is accepted, `outValid` falls after the next edge.
- R9: While `outValid` is 1 and `outReady` is 0, `inReady` is 0, and the outputs stay unchanged.
- R10: The mode is sampled only on the accepting edge. Changes on `inMode` or `inAddr` while a result is held have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Request address is valid |
| inReady | output | 1 | Mapper can accept a request this cycle |
| inAddr | input | ADDR_W | Physical byte address |
| inMode | input | 1 | Interleaving scheme: 0 = open-page, 1 = closed-page |
| outValid | output | 1 | Decoded coordinates are valid |
| outReady | input | 1 | Consumer takes the coordinates this cycle |
| outRank | output | 8 | Decoded rank index |
| outBank | output | 16 | Decoded bank index |
| outRow | output | 16 | Decoded row index |

## Verification
The bench builds the mapper with a 24-bit address, 16-byte lines, 8 lines per row buffer, 4 banks, 2 ranks and 64 rows. The decoded fields then use only bits 4 to 15, so random addresses set the eight bits above the row field, and the R7 check becomes meaningful. A small geometry also lets short runs of consecutive lines cover a whole row buffer and every bank, as R5 and R6 require. In addition, random 24-bit addresses reach every value of each field in both modes.

// File: rtl/dram_coord_pkg.sv
package dram_coord_pkg;

  typedef enum logic {
    MAP_OPEN   = 1'b0,
    MAP_CLOSED = 1'b1
  } map_mode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic      capture;
    map_mode_e scheme;
  } map_strobe_t;

  // decoded coordinates, fixed output widths
  typedef struct packed {
    logic [7:0]  rank;
    logic [15:0] bank;
    logic [15:0] row;
  } dram_coord_t;

endpackage

// File: rtl/map_ctrl.sv
module map_ctrl
  import dram_coord_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  input  logic        inMode,
  input  logic        outReady,
  output logic        inReady,
  output logic        outValid,
  output map_strobe_t strobe
);

  logic holdReg;
  logic accept;

  assign inReady = !holdReg || outReady;
  assign accept  = inValid && inReady;

  assign strobe.capture = accept;
  assign strobe.scheme  = map_mode_e'(inMode);

  always_ff @(posedge clk) begin
    if (rst) begin
      holdReg <= 1'b0;
    end else if (accept) begin
      holdReg <= 1'b1;
    end else if (outReady) begin
      holdReg <= 1'b0;
    end
  end

  assign outValid = holdReg;

  // R8: an accepted request leaves a valid result behind it
  p_accept_valid_r8: assert property (@(posedge clk) disable iff (rst)
    (inValid && inReady) |=> outValid);

endmodule

// File: rtl/map_datapath.sv
module map_datapath
  import dram_coord_pkg::*;
#(
  parameter int ADDR_W        = 40,
  parameter int LINE_BYTES    = 64,
  parameter int LINES_PER_ROW = 128,
  parameter int BANKS         = 8,
  parameter int RANKS         = 2,
  parameter int ROWS          = 32768
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] inAddr,
  input  map_strobe_t       strobe,
  output dram_coord_t       coord
);

  localparam int LINE_SH = $clog2(LINE_BYTES);
  localparam int COL_W   = $clog2(LINES_PER_ROW);
  localparam int BANK_W  = $clog2(BANKS);
  localparam int RANK_W  = $clog2(RANKS);

  localparam logic [ADDR_W-1:0] BANK_MASK = ADDR_W'(BANKS - 1);
  localparam logic [ADDR_W-1:0] RANK_MASK = ADDR_W'(RANKS - 1);
  localparam logic [ADDR_W-1:0] ROW_MASK  = ADDR_W'(ROWS - 1);

  dram_coord_t cand [2];
  dram_coord_t nextCoord;

  // index 0: column, bank, rank, row; index 1: bank, rank, column, row
  for (genvar s = 0; s < 2; s++) begin : g_scheme
    localparam int BANK_SH = (s == 0) ? LINE_SH + COL_W : LINE_SH;
    localparam int RANK_SH = BANK_SH + BANK_W;
    localparam int ROW_SH  = (s == 0) ? RANK_SH + RANK_W
                                      : RANK_SH + RANK_W + COL_W;
    assign cand[s] = {8'((inAddr >> RANK_SH) & RANK_MASK),
                      16'((inAddr >> BANK_SH) & BANK_MASK),
                      16'((inAddr >> ROW_SH) & ROW_MASK)};
  end

  assign nextCoord = (strobe.scheme == MAP_CLOSED) ? cand[1] : cand[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      coord <= '0;
    end else if (strobe.capture) begin
      coord <= nextCoord;
    end
  end

  // R3/R4: registered fields never leave their geometry range
  p_bank_range_r3: assert property (@(posedge clk) disable iff (rst)
    32'(coord.bank) < BANKS);
  p_rank_range_r4: assert property (@(posedge clk) disable iff (rst)
    32'(coord.rank) < RANKS);

endmodule

// File: rtl/dram_coord_mapper.sv
module dram_coord_mapper
  import dram_coord_pkg::*;
#(
  parameter int ADDR_W        = 40,
  parameter int LINE_BYTES    = 64,
  parameter int LINES_PER_ROW = 128,
  parameter int BANKS         = 8,
  parameter int RANKS         = 2,
  parameter int ROWS          = 32768
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  output logic              inReady,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic              inMode,
  output logic              outValid,
  input  logic              outReady,
  output logic [7:0]        outRank,
  output logic [15:0]       outBank,
  output logic [15:0]       outRow
);

  map_strobe_t strobe;
  dram_coord_t coord;

  map_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .inMode   (inMode),
    .outReady (outReady),
    .inReady  (inReady),
    .outValid (outValid),
    .strobe   (strobe)
  );

  map_datapath #(
    .ADDR_W        (ADDR_W),
    .LINE_BYTES    (LINE_BYTES),
    .LINES_PER_ROW (LINES_PER_ROW),
    .BANKS         (BANKS),
    .RANKS         (RANKS),
    .ROWS          (ROWS)
  ) u_dp (
    .clk    (clk),
    .rst    (rst),
    .inAddr (inAddr),
    .strobe (strobe),
    .coord  (coord)
  );

  assign outRank = coord.rank;
  assign outBank = coord.bank;
  assign outRow  = coord.row;

  // geometry must be powers of two that fit the output widths
  initial begin : elab_checks
    a_line_pow2: assert (LINE_BYTES > 0 && (LINE_BYTES & (LINE_BYTES - 1)) == 0)
      else $error("LINE_BYTES must be a power of two");
    a_col_pow2: assert (LINES_PER_ROW > 0 && (LINES_PER_ROW & (LINES_PER_ROW - 1)) == 0)
      else $error("LINES_PER_ROW must be a power of two");
    a_bank_pow2: assert (BANKS > 0 && BANKS <= 65536 && (BANKS & (BANKS - 1)) == 0)
      else $error("BANKS must be a power of two up to 65536");
    a_rank_pow2: assert (RANKS > 0 && RANKS <= 256 && (RANKS & (RANKS - 1)) == 0)
      else $error("RANKS must be a power of two up to 256");
    a_row_pow2: assert (ROWS > 0 && ROWS <= 65536 && (ROWS & (ROWS - 1)) == 0)
      else $error("ROWS must be a power of two up to 65536");
  end

  // R1: reset empties the output stage
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!outValid && outRank == 8'd0 && outBank == 16'd0 && outRow == 16'd0));

  // R9: a stalled result is held unchanged
  p_hold_stable_r9: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> (outValid && $stable(outRank) && $stable(outBank)
                                 && $stable(outRow)));

  // R8: a consumed result with no new request drains
  p_drain_r8: assert property (@(posedge clk) disable iff (rst)
    (outValid && outReady && !inValid) |=> !outValid);

endmodule

// File: tb/dram_coord_mapper_bench.sv
module dram_coord_mapper_bench;

  localparam int AW  = 24;
  localparam int LB  = 16;
  localparam int LPR = 8;
  localparam int BK  = 4;
  localparam int RK  = 2;
  localparam int RW  = 64;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          inValid = 1'b0;
  logic          inReady;
  logic [AW-1:0] inAddr = '0;
  logic          inMode = 1'b0;
  logic          outValid;
  logic          outReady = 1'b0;
  logic [7:0]    outRank;
  logic [15:0]   outBank;
  logic [15:0]   outRow;

  int    total = 0;
  int    bad = 0;
  bit    done = 1'b0;
  string curReq = "R1";

  // reference model state
  bit          expValid = 1'b0;
  logic [39:0] expCoord = '0;
  logic [39:0] seen [$];

  always #5 clk = ~clk;

  dram_coord_mapper #(
    .ADDR_W(AW), .LINE_BYTES(LB), .LINES_PER_ROW(LPR),
    .BANKS(BK), .RANKS(RK), .ROWS(RW)
  ) u_dram_coord_mapper (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
    .inAddr(inAddr), .inMode(inMode), .outValid(outValid),
    .outReady(outReady), .outRank(outRank), .outBank(outBank), .outRow(outRow)
  );

  function automatic logic [39:0] refMap(input logic [AW-1:0] a, input logic m);
    longint l, bank, rank, row;
    l = longint'(a) / LB;
    if (!m) begin
      l = l / LPR;
      bank = l % BK; l = l / BK;
      rank = l % RK; l = l / RK;
      row  = l % RW;
    end else begin
      bank = l % BK; l = l / BK;
      rank = l % RK; l = l / RK;
      l = l / LPR;
      row  = l % RW;
    end
    return {8'(rank), 16'(bank), 16'(row)};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input logic v, input logic m, input logic [AW-1:0] a,
                      input logic r);
    logic [39:0] act;
    bit rdyExp;
    @(negedge clk);
    act = {outRank, outBank, outRow};
    check(outValid == expValid, curReq, "outValid", longint'(outValid), longint'(expValid));
    check(act == expCoord, curReq, "coord", longint'(act), longint'(expCoord));
    inValid = v; inMode = m; inAddr = a; outReady = r;
    #1;
    rdyExp = !expValid || r;
    check(inReady == rdyExp, curReq, "inReady", longint'(inReady), longint'(rdyExp));
    if (expValid && r) seen.push_back(act);
    if (v && rdyExp) begin
      expValid = 1'b1;
      expCoord = refMap(a, m);
    end else if (r) begin
      expValid = 1'b0;
    end
  endtask

  function automatic logic [AW-1:0] lineAddr(input int line, input int off);
    return AW'(line * LB + off);
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R8 watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    int base;
    repeat (2) @(negedge clk);
    // R1: reset state
    check(outValid == 1'b0, "R1", "outValid", longint'(outValid), 0);
    check({outRank, outBank, outRow} == 40'd0, "R1", "coord",
          longint'({outRank, outBank, outRow}), 0);
    check(inReady == 1'b1, "R1", "inReady", longint'(inReady), 1);
    rst = 1'b0;

    // R8: single request latency and drain
    curReq = "R8";
    tick(1'b1, 1'b0, AW'(24'h00_1234), 1'b1);
    tick(1'b0, 1'b0, '0, 1'b1);
    tick(1'b0, 1'b0, '0, 1'b1);
    tick(1'b1, 1'b1, AW'(24'h00_5670), 1'b1);
    tick(1'b1, 1'b0, AW'(24'h00_9abc), 1'b1);
    tick(1'b0, 1'b0, '0, 1'b1);

    // R3: random traffic, open-page
    curReq = "R3";
    for (int i = 0; i < 300; i++)
      tick(1'($urandom), 1'b0, AW'($urandom) & AW'(16'hffff), 1'($urandom));
    // R4: random traffic, closed-page
    curReq = "R4";
    for (int i = 0; i < 300; i++)
      tick(1'($urandom), 1'b1, AW'($urandom) & AW'(16'hffff), 1'($urandom));
    tick(1'b0, 1'b0, '0, 1'b1);

    // R5: one row buffer of consecutive lines, open-page
    curReq = "R5";
    seen.delete();
    base = LPR * 37;
    for (int i = 0; i < LPR; i++) tick(1'b1, 1'b0, lineAddr(base + i, 0), 1'b1);
    tick(1'b0, 1'b0, '0, 1'b1);
    tick(1'b0, 1'b0, '0, 1'b1);
    check(seen.size() == LPR, "R5", "count", longint'(seen.size()), LPR);
    for (int i = 1; i < seen.size(); i++)
      check(seen[i] == seen[0], "R5", "same row/bank/rank",
            longint'(seen[i]), longint'(seen[0]));

    // R6: consecutive lines walk the banks, closed-page
    curReq = "R6";
    seen.delete();
    base = BK * 53;
    for (int i = 0; i < BK; i++) tick(1'b1, 1'b1, lineAddr(base + i, 0), 1'b1);
    tick(1'b0, 1'b0, '0, 1'b1);
    tick(1'b0, 1'b0, '0, 1'b1);
    check(seen.size() == BK, "R6", "count", longint'(seen.size()), BK);
    for (int i = 0; i < seen.size(); i++)
      check(seen[i][31:16] == 16'(i), "R6", "bank order",
            longint'(seen[i][31:16]), longint'(i));

    // R2: offset within line is discarded
    curReq = "R2";
    for (int g = 0; g < 20; g++) begin
      base = int'($urandom % 4096);
      seen.delete();
      for (int k = 0; k < 4; k++)
        tick(1'b1, 1'(g), lineAddr(base, int'($urandom % LB)), 1'b1);
      tick(1'b0, 1'b0, '0, 1'b1);
      tick(1'b0, 1'b0, '0, 1'b1);
      for (int k = 1; k < seen.size(); k++)
        check(seen[k] == seen[0], "R2", "offset ignored",
              longint'(seen[k]), longint'(seen[0]));
    end

    // R7: bits above the row field are ignored
    curReq = "R7";
    for (int i = 0; i < 30; i++) begin
      logic [AW-1:0] a;
      a = AW'($urandom) & AW'(16'hffff);
      seen.delete();
      tick(1'b1, 1'(i), a, 1'b1);
      tick(1'b1, 1'(i), a | AW'({8'($urandom | 1), 16'h0}), 1'b1);
      tick(1'b0, 1'b0, '0, 1'b1);
      tick(1'b0, 1'b0, '0, 1'b1);
      check(seen.size() == 2 && seen[1] == seen[0], "R7", "high bits ignored",
            longint'(seen[seen.size()-1]), longint'(seen[0]));
    end
    for (int i = 0; i < 200; i++)
      tick(1'($urandom), 1'($urandom), AW'($urandom), 1'($urandom));
    tick(1'b0, 1'b0, '0, 1'b1);

    // R9: backpressure holds result and blocks input
    curReq = "R9";
    tick(1'b1, 1'b0, AW'(24'h00_3a50), 1'b0);
    for (int i = 0; i < 5; i++) tick(1'b1, 1'b0, AW'($urandom), 1'b0);
    // R10: mode and address changes during a hold have no effect
    curReq = "R10";
    for (int i = 0; i < 6; i++) tick(1'b1, 1'(i), AW'($urandom), 1'b0);
    tick(1'b0, 1'b1, '0, 1'b1);
    tick(1'b0, 1'b0, '0, 1'b1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule